// File: doc/BRIEF.md
# Receive Byte Queue with Fill-Level and Idle-Timeout Interrupts

This block sits between a serial receiver's shift register and a processor read port. Each byte the receiver finishes is pushed into a 16-entry first-in first-out store. The processor sees the oldest stored byte on a show-ahead data output and removes it with a read strobe. The current occupancy is always visible on a count output.

Two interrupt lines tell the processor when to come and read. The fill-level interrupt rises once the occupancy reaches a threshold picked by a 2-bit select. The idle-timeout interrupt covers the tail of a message whose length leaves it below that threshold. It fires when data has been waiting and the queue has gone four character times with neither a push nor a read. A character time is measured in baud ticks, which arrive at 16 times the bit rate, multiplied by the bits-per-character input. A byte that arrives while the queue is full is dropped, and a sticky overrun flag records the loss until a status-read strobe clears it.

Top module: `rx_fifo_intr`

## Requirements
- R1: After reset, the count is 0, both interrupt lines are low and the overrun flag is low.
- R2: Bytes leave in arrival order. `rd_data` shows the oldest stored byte. Each accepted push adds 1 to `fill_cnt` and each read of a non-empty queue subtracts 1.
- R3: The queue holds at most 16 bytes. A push while it is full and no read occurs in that cycle is discarded, leaving the count at 16 and the stored bytes unchanged.
- R4: A push that is discarded because the queue is full sets `overrun` on the next cycle. The flag stays set until a `stat_rd` pulse clears it.
- R5: `trig_sel` encodes the fill threshold as 0→1, 1→4, 2→8 and 3→14 bytes. `irq_data` is high when `irq_en` is 1 and `fill_cnt` is at or above the threshold.
- R6: `irq_data` drops in the same cycle that `fill_cnt` falls below the threshold.
- R7: With `irq_en` at 0, both `irq_data` and `irq_tmo` stay low. Setting `irq_en` exposes pending conditions at once.
- R8: With at least one byte stored and no `rx_wr` or `cpu_rd`, `irq_tmo` rises on the baud tick that completes 64×`char_bits` ticks since the last such strobe, and not before.
- R9: A `cpu_rd` or `rx_wr` pulse clears `irq_tmo` and restarts the timeout count from zero.
- R10: While the queue is empty, the timeout count is held at zero and `irq_tmo` never asserts, whatever the baud ticks do.
- R11: A push and a read in the same cycle on a non-empty queue leave `fill_cnt` unchanged, advance the head, and restart the timeout count.
- R12: A read strobe on an empty queue is ignored, and `fill_cnt` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_wr | input | 1 | Strobe: the receiver has a finished byte |
| rx_data | input | 8 | Byte from the receiver |
| cpu_rd | input | 1 | Strobe: the processor removes the head byte |
| rd_data | output | 8 | Oldest stored byte (show-ahead) |
| trig_sel | input | 2 | Fill-threshold select (1, 4, 8, 14) |
| irq_en | input | 1 | Enable for both interrupt lines |
| baud_tick | input | 1 | One pulse per 1/16 bit time |
| char_bits | input | 4 | Bits per character, including start, stop and parity |
| stat_rd | input | 1 | Strobe that clears the overrun flag |
| fill_cnt | output | 5 | Number of bytes stored (0 to 16) |
| irq_data | output | 1 | Fill-level interrupt |
| irq_tmo | output | 1 | Idle-timeout interrupt |
| overrun | output | 1 | Sticky flag for a dropped byte |

## Verification
The bench targets the exact tick on which the timeout fires. It checks one tick before and on the tick itself, so a timer that is off by one, or that counts while the queue is empty, is exposed. It fills the queue to capacity and pushes once more. A design that wraps its pointers would corrupt the oldest byte or report a count of 0, while one that misses the overrun would leave the flag low. Each threshold code is walked just below and at its level, and then one byte is read. This catches a wrong decode or an interrupt that lingers after the level drops. A simultaneous push and read checks that the count holds while the head advances, and that the timer restarts.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

   // Map the 2-bit threshold select to a byte count for a queue of the given depth.
   function automatic int trig_level(input logic [1:0] sel, input int depth);
      case (sel)
         2'd0:    return 1;
         2'd1:    return depth / 4;
         2'd2:    return depth / 2;
         default: return depth - 2;
      endcase
   endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] din,
   input  logic              pop,
   output logic [DATA_W-1:0] dout,
   output logic [CNT_W-1:0]  count,
   output logic              empty,
   output logic              dropped
);

   initial begin
      if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0)
         $error("rxq_store: DEPTH must be a power of two and at least 4");
      if (DATA_W < 1)
         $error("rxq_store: DATA_W must be positive");
   end

   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic [DATA_W-1:0] slot [DEPTH];
   logic              full, pop_ok, push_ok;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign pop_ok  = pop && !empty;
   assign push_ok = push && (!full || pop_ok);
   assign dropped = push && full && !pop_ok;
   assign dout    = slot[rd_ptr];

   for (genvar e = 0; e < DEPTH; e++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot[e] <= '0;
         else if (push_ok && wr_ptr == PTR_W'(e))
            slot[e] <= din;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         case ({push_ok, pop_ok})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNT_W'(DEPTH));

   a_r3_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> count == CNT_W'(DEPTH));

   a_r11_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (push && pop && !empty) |=> $stable(count));

   a_r12_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push) |=> count == '0);

endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
   parameter int CB_W      = 4,
   parameter int OVS       = 16,
   parameter int TMO_CHARS = 4,
   localparam int MAX_TICKS = TMO_CHARS * OVS * ((1 << CB_W) - 1),
   localparam int TMR_W     = $clog2(MAX_TICKS + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            empty,
   input  logic            activity,
   input  logic            tick,
   input  logic [CB_W-1:0] char_bits,
   output logic            expired
);

   initial begin
      if (OVS < 1 || TMO_CHARS < 1 || CB_W < 1)
         $error("rxq_timer: OVS, TMO_CHARS and CB_W must be positive");
   end

   logic [TMR_W-1:0] ticks;
   logic [TMR_W:0]   limit, nxt;

   assign limit = (TMR_W + 1)'(TMO_CHARS * OVS) * (TMR_W + 1)'(char_bits);
   assign nxt   = {1'b0, ticks} + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ticks   <= '0;
         expired <= 1'b0;
      end else if (empty || activity) begin
         ticks   <= '0;
         expired <= 1'b0;
      end else if (tick && !expired) begin
         ticks <= nxt[TMR_W-1:0];
         if (nxt >= limit) expired <= 1'b1;
      end
   end

   a_r10_empty_idle: assert property (@(posedge clk) disable iff (!rst_n)
      empty |=> (!expired || !empty));

   a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
      activity |=> !expired);

endmodule

// File: rtl/rx_fifo_intr.sv
module rx_fifo_intr #(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 16,
   parameter int CB_W      = 4,
   parameter int OVS       = 16,
   parameter int TMO_CHARS = 4,
   localparam int CNT_W    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_wr,
   input  logic [DATA_W-1:0] rx_data,
   input  logic              cpu_rd,
   output logic [DATA_W-1:0] rd_data,
   input  logic [1:0]        trig_sel,
   input  logic              irq_en,
   input  logic              baud_tick,
   input  logic [CB_W-1:0]   char_bits,
   input  logic              stat_rd,
   output logic [CNT_W-1:0]  fill_cnt,
   output logic              irq_data,
   output logic              irq_tmo,
   output logic              overrun
);

   import rxq_pkg::*;

   logic             empty, dropped, tmo_hit;
   logic [CNT_W-1:0] level;

   rxq_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (rx_wr),
      .din     (rx_data),
      .pop     (cpu_rd),
      .dout    (rd_data),
      .count   (fill_cnt),
      .empty   (empty),
      .dropped (dropped)
   );

   rxq_timer #(.CB_W(CB_W), .OVS(OVS), .TMO_CHARS(TMO_CHARS)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .empty     (empty),
      .activity  (rx_wr || cpu_rd),
      .tick      (baud_tick),
      .char_bits (char_bits),
      .expired   (tmo_hit)
   );

   assign level    = CNT_W'(trig_level(trig_sel, DEPTH));
   assign irq_data = irq_en && (fill_cnt >= level);
   assign irq_tmo  = irq_en && tmo_hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         overrun <= 1'b0;
      else if (dropped)
         overrun <= 1'b1;
      else if (stat_rd)
         overrun <= 1'b0;
   end

   a_r4_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      dropped |=> overrun);

   a_r4_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !stat_rd) |=> overrun);

   a_r7_masked: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en |-> (!irq_data && !irq_tmo));

endmodule

// File: tb/rx_fifo_intr_bench.sv
module rx_fifo_intr_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_wr = 1'b0, cpu_rd = 1'b0, irq_en = 1'b1, baud_tick = 1'b0, stat_rd = 1'b0;
   logic [7:0] rx_data = '0, rd_data;
   logic [1:0] trig_sel = 2'd0;
   logic [3:0] char_bits = 4'd2;
   logic [4:0] fill_cnt;
   logic       irq_data, irq_tmo, overrun;

   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   rx_fifo_intr u_rx_fifo_intr (
      .clk(clk), .rst_n(rst_n), .rx_wr(rx_wr), .rx_data(rx_data), .cpu_rd(cpu_rd),
      .rd_data(rd_data), .trig_sel(trig_sel), .irq_en(irq_en), .baud_tick(baud_tick),
      .char_bits(char_bits), .stat_rd(stat_rd), .fill_cnt(fill_cnt), .irq_data(irq_data),
      .irq_tmo(irq_tmo), .overrun(overrun)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      rx_wr = 0; cpu_rd = 0; stat_rd = 0; baud_tick = 0; irq_en = 1;
      @(negedge clk) rst_n = 0;
      @(negedge clk) rst_n = 1;
      @(negedge clk);
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk) begin rx_wr = 1; rx_data = b; end
      @(negedge clk) rx_wr = 0;
   endtask

   task automatic pop();
      @(negedge clk) cpu_rd = 1;
      @(negedge clk) cpu_rd = 0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      chk("R1 count", fill_cnt, 0);
      chk("R1 irq_data", irq_data, 0);
      chk("R1 irq_tmo", irq_tmo, 0);
      chk("R1 overrun", overrun, 0);
   endtask

   task automatic t_empty_read();
      do_reset();
      pop();
      chk("R12 count after empty read", fill_cnt, 0);
      push(8'h5A);
      chk("R12 head after empty read", rd_data, 8'h5A);
   endtask

   task automatic t_full_overrun();
      do_reset();
      trig_sel = 2'd3;
      for (int i = 0; i < 16; i++) push(8'(i * 3 + 1));
      chk("R3 count full", fill_cnt, 16);
      chk("R4 no overrun yet", overrun, 0);
      push(8'hEE);
      chk("R3 count after extra", fill_cnt, 16);
      chk("R4 overrun set", overrun, 1);
      for (int i = 0; i < 16; i++) begin
         chk("R2 order", rd_data, i * 3 + 1);
         pop();
         chk("R2 count down", fill_cnt, 15 - i);
      end
      chk("R4 overrun sticky", overrun, 1);
      @(negedge clk) stat_rd = 1;
      @(negedge clk) stat_rd = 0;
      chk("R4 overrun cleared", overrun, 0);
   endtask

   task automatic t_trigger();
      int lv;
      for (int s = 0; s < 4; s++) begin
         do_reset();
         trig_sel = 2'(s);
         lv = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
         for (int i = 0; i < lv - 1; i++) push(8'(i));
         chk("R5 below level", irq_data, 0);
         push(8'hA5);
         chk("R5 at level", irq_data, 1);
         pop();
         chk("R6 drop below level", irq_data, 0);
      end
   endtask

   task automatic t_mask();
      do_reset();
      trig_sel = 2'd3; irq_en = 0; char_bits = 4'd2;
      for (int i = 0; i < 14; i++) push(8'(i));
      baud_tick = 1;
      idle(200);
      chk("R7 data masked", irq_data, 0);
      chk("R7 tmo masked", irq_tmo, 0);
      irq_en = 1;
      #1;
      chk("R7 data unmasked", irq_data, 1);
      chk("R7 tmo unmasked", irq_tmo, 1);
      baud_tick = 0;
   endtask

   task automatic t_timeout();
      do_reset();
      trig_sel = 2'd3; char_bits = 4'd2; baud_tick = 1;
      push(8'h11);
      idle(127);
      chk("R8 one tick early", irq_tmo, 0);
      idle(1);
      chk("R8 fires on limit", irq_tmo, 1);
      push(8'h22);
      chk("R9 push clears", irq_tmo, 0);
      idle(127);
      chk("R9 restart early", irq_tmo, 0);
      idle(1);
      chk("R9 restart fires", irq_tmo, 1);
      pop();
      chk("R9 read clears", irq_tmo, 0);
      chk("R9 count", fill_cnt, 1);
      char_bits = 4'd3;
      idle(190);
      chk("R8 longer char early", irq_tmo, 0);
      idle(2);
      chk("R8 longer char fires", irq_tmo, 1);
      baud_tick = 0;
   endtask

   task automatic t_empty_timer();
      do_reset();
      char_bits = 4'd2; baud_tick = 1;
      idle(300);
      chk("R10 empty no tmo", irq_tmo, 0);
      push(8'h33);
      idle(127);
      chk("R10 timer started at zero", irq_tmo, 0);
      idle(1);
      chk("R10 fires after fill", irq_tmo, 1);
      baud_tick = 0;
   endtask

   task automatic t_simul();
      do_reset();
      trig_sel = 2'd3; char_bits = 4'd2; baud_tick = 1;
      push(8'hA1); push(8'hA2); push(8'hA3);
      idle(100);
      @(negedge clk) begin rx_wr = 1; cpu_rd = 1; rx_data = 8'hA4; end
      @(negedge clk) begin rx_wr = 0; cpu_rd = 0; end
      chk("R11 count held", fill_cnt, 3);
      chk("R11 head advanced", rd_data, 8'hA2);
      idle(127);
      chk("R11 timer restarted", irq_tmo, 0);
      idle(1);
      chk("R11 timer fires", irq_tmo, 1);
      baud_tick = 0;
      pop(); pop();
      chk("R11 new byte kept", rd_data, 8'hA4);
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_empty_read();
            t_full_overrun();
            t_trigger();
            t_mask();
            t_timeout();
            t_empty_timer();
            t_simul();
         end
         begin
            repeat (100000) @(posedge clk);
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
         end
      join_any
      disable fork;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule